// File: doc/BRIEF.md
# PWM generator with selectable update timing

This block is a single-channel pulse-width modulator. The period is fixed at 256 clocks. An 8-bit compare value sets how many clocks of each period the output is active, and a separate full-scale flag gives a fully active output. The output polarity can be normal or inverted. Software drives a one-cycle write port. Each write carries the duty value, the full-scale flag, the polarity and the run bit, plus a bit that chooses when the new duty and polarity take effect.

An immediate write replaces the live configuration on the next clock. Because of this, the period that is running when the write lands can come out truncated or stretched. A deferred write parks the new configuration in a shadow register. The shadow register is copied into the live one when the counter wraps from 255 to 0, so every period that is emitted belongs to exactly one configuration. A status output stays high while a deferred update is waiting. Clearing the run bit forces the output to its inactive level at once. Setting it again restarts the period from count 0.

Top module: `pwm_gen`

## Requirements
- R1: After reset the output is low, the pending flag is low and the generator is stopped.
- R2: While running, the period counter steps once per clock through 0..255 and wraps. In the first clock after the run bit goes from 0 to 1 the counter is 0. With normal polarity the output is high exactly in the clocks whose count is below the compare value, so a period holds `duty` high clocks.
- R3: A compare value of 0 with the full-scale flag clear gives a constant inactive level in every period, with no pulse.
- R4: With the full-scale flag set, the output is active in every clock of every period, whatever the compare value.
- R5: With the invert bit set, the running output is the complement of the normal-polarity waveform.
- R6: A write with the defer bit at 0 changes the live duty and polarity in the very next clock, inside the current period.
- R7: A write with the defer bit at 1 leaves the live configuration untouched and raises the pending flag. The stored value becomes live in the first clock after the 255-to-0 wrap, and the pending flag drops in that same clock.
- R8: If several deferred writes arrive before a wrap, only the last one is applied at the boundary.
- R9: An immediate write discards any waiting deferred value and clears the pending flag on the next clock.
- R10: The polarity bit obeys the same defer bit as the duty value, so a deferred polarity change appears only from the boundary on.
- R11: A write that clears the run bit makes the output take its inactive level (low for normal polarity, high for inverted) on the next clock, and the output holds that level while stopped.
- R12: Setting the run bit again starts a fresh period at count 0 using the live configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | One-cycle write strobe |
| wr_duty | input | 8 | Compare value (active clocks per period) |
| wr_full | input | 1 | Full-scale flag, forces 100% duty |
| wr_inv | input | 1 | 1 = inverted active level |
| wr_run | input | 1 | Run bit, 0 stops the output |
| wr_defer | input | 1 | 1 = apply duty/polarity at next wrap, 0 = at once |
| pwm_out | output | 1 | PWM output |
| upd_pending | output | 1 | A deferred configuration is waiting for the wrap |

## Verification
A corrupted period counter shows up as a wrong number of high clocks within a single 256-clock window. It can also show up as a first period after restart that does not open with an active pulse. A stale live register, or a shadow register copied at the wrong moment, shows up in the first period after the wrap: that period holds the old high count, or a count belonging to a discarded value. A wrong pending flag is visible on its status pin in the clock after the write or after the wrap. So every internal fault of interest appears at the ports within one period plus one clock.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  parameter int unsigned PWM_W = 8;

  typedef struct packed {
    logic [PWM_W-1:0] duty;
    logic             full;
    logic             inv;
  } pwm_cfg_t;
endpackage

// File: rtl/pwm_rst_sync.sv
module pwm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/pwm_tick_counter.sv
module pwm_tick_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_d,
  output logic         run_q,
  output logic [W-1:0] cnt_q,
  output logic         wrap
);
  localparam logic [W-1:0] CNT_MAX = '1;

  logic [W-1:0] cnt_d;

  always_comb begin
    if (run_q && run_d) cnt_d = cnt_q + 1'b1;
    else                cnt_d = '0;
  end

  assign wrap = run_q && run_d && (cnt_q == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

  assert_wrap_to_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && run_d && cnt_q == CNT_MAX) |=> (cnt_q == '0));

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && run_d && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1));

  assert_restart_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && run_d) |=> (cnt_q == '0));
endmodule

// File: rtl/pwm_cfg_bank.sv
module pwm_cfg_bank
  import pwm_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_valid,
  input  logic     wr_defer,
  input  pwm_cfg_t wr_cfg,
  input  logic     wrap,
  output pwm_cfg_t live_q,
  output logic     pend_q
);
  pwm_cfg_t live_d, shad_d, shad_q;
  logic     pend_d;
  logic     bank_ce;

  assign bank_ce = wr_valid | (wrap & pend_q);

  always_comb begin
    live_d = live_q;
    shad_d = shad_q;
    pend_d = pend_q;
    if (wrap && pend_q) begin
      live_d = shad_q;
      pend_d = 1'b0;
    end
    if (wr_valid) begin
      if (wr_defer) begin
        shad_d = wr_cfg;
        pend_d = 1'b1;
      end else begin
        live_d = wr_cfg;
        pend_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= '0;
      shad_q <= '0;
      pend_q <= 1'b0;
    end else if (bank_ce) begin
      live_q <= live_d;
      shad_q <= shad_d;
      pend_q <= pend_d;
    end
  end

  assert_boundary_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && pend_q && !wr_valid) |=> (live_q == $past(shad_q) && !pend_q));

  assert_pending_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !wrap && !wr_valid) |=> (pend_q && $stable(live_q)));

  assert_defer_keeps_live_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_defer && !(wrap && pend_q)) |=> $stable(live_q));

  assert_cancel_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_defer) |=> !pend_q);
endmodule

// File: rtl/pwm_level_drive.sv
module pwm_level_drive
  import pwm_pkg::*;
(
  input  logic             run_q,
  input  logic [PWM_W-1:0] cnt_q,
  input  pwm_cfg_t         live,
  output logic             pwm_out
);
  logic on_phase;

  always_comb begin
    on_phase = run_q && (live.full || (cnt_q < live.duty));
    pwm_out  = on_phase ^ live.inv;
  end
endmodule

// File: rtl/pwm_gen.sv
module pwm_gen
  import pwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic [PWM_W-1:0] wr_duty,
  input  logic             wr_full,
  input  logic             wr_inv,
  input  logic             wr_run,
  input  logic             wr_defer,
  output logic             pwm_out,
  output logic             upd_pending
);
  logic             rst_sync_n;
  logic             run_d, run_q, wrap;
  logic [PWM_W-1:0] cnt_q;
  pwm_cfg_t         wr_cfg, live_q;

  assign wr_cfg = '{duty: wr_duty, full: wr_full, inv: wr_inv};
  assign run_d  = wr_valid ? wr_run : run_q;

  pwm_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pwm_tick_counter #(.W(PWM_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .run_d (run_d),
    .run_q (run_q),
    .cnt_q (cnt_q),
    .wrap  (wrap)
  );

  pwm_cfg_bank u_cfg (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_valid (wr_valid),
    .wr_defer (wr_defer),
    .wr_cfg   (wr_cfg),
    .wrap     (wrap),
    .live_q   (live_q),
    .pend_q   (upd_pending)
  );

  pwm_level_drive u_drv (
    .run_q   (run_q),
    .cnt_q   (cnt_q),
    .live    (live_q),
    .pwm_out (pwm_out)
  );

  assert_stop_inactive_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_valid && !wr_run && !wr_defer) |=> (pwm_out == $past(wr_inv)));

  assert_stopped_holds_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!run_q && !wr_valid) |=> (!run_q && pwm_out == $past(pwm_out)));

  assert_full_active_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (run_q && run_d && live_q.full && !wr_valid && !(wrap && upd_pending))
      |=> (pwm_out == !live_q.inv));
endmodule

// File: tb/sim_pwm_gen.sv
module sim_pwm_gen;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_valid, wr_full, wr_inv, wr_run, wr_defer;
  logic [7:0] wr_duty;
  logic       pwm_out, upd_pending;
  int         total = 0;
  int         bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_gen u0 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_duty(wr_duty),
    .wr_full(wr_full), .wr_inv(wr_inv), .wr_run(wr_run), .wr_defer(wr_defer),
    .pwm_out(pwm_out), .upd_pending(upd_pending)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive at a negedge, return at the next negedge (write already applied)
  task automatic do_write(input int duty, input bit full, input bit inv,
                          input bit run, input bit defer);
    wr_valid = 1'b1; wr_duty = duty[7:0]; wr_full = full;
    wr_inv = inv; wr_run = run; wr_defer = defer;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic count_hi(input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      hi += int'(pwm_out);
      @(negedge clk);
    end
  endtask

  // stop then restart; returns in cycle 0 of a fresh period
  task automatic start(input int duty, input bit full, input bit inv);
    do_write(0, 1'b0, 1'b0, 1'b0, 1'b0);
    do_write(duty, full, inv, 1'b1, 1'b0);
  endtask

  task automatic t_reset;
    chk("R1 out", int'(pwm_out), 0);
    chk("R1 pending", int'(upd_pending), 0);
  endtask

  task automatic t_basic;
    int hi;
    start(128, 1'b0, 1'b0);
    chk("R2 first clock active", int'(pwm_out), 1);
    count_hi(256, hi); chk("R2 duty128", hi, 128);
    count_hi(256, hi); chk("R2 second period", hi, 128);
    start(1, 1'b0, 1'b0);
    count_hi(256, hi); chk("R2 duty1", hi, 1);
  endtask

  task automatic t_zero_full;
    int hi;
    start(0, 1'b0, 1'b0);
    count_hi(512, hi); chk("R3 zero duty", hi, 0);
    start(0, 1'b1, 1'b0);
    count_hi(512, hi); chk("R4 full duty", hi, 512);
    start(255, 1'b0, 1'b0);
    count_hi(256, hi); chk("R4 255 is not full", hi, 255);
  endtask

  task automatic t_invert;
    int hi;
    start(64, 1'b0, 1'b1);
    count_hi(256, hi); chk("R5 inverted", hi, 192);
  endtask

  task automatic t_immediate;
    int hi;
    start(200, 1'b0, 1'b0);
    count_hi(100, hi);
    do_write(50, 1'b0, 0, 1'b1, 1'b0);
    chk("R6 cut short", int'(pwm_out), 0);
    count_hi(155, hi); chk("R6 rest low", hi, 0);
    count_hi(256, hi); chk("R6 new period", hi, 50);
    start(50, 1'b0, 1'b0);
    count_hi(100, hi);
    do_write(200, 1'b0, 0, 1'b1, 1'b0);
    chk("R6 stretched", int'(pwm_out), 1);
    count_hi(155, hi); chk("R6 stretched count", hi, 99);
  endtask

  task automatic t_deferred;
    int hi;
    start(64, 1'b0, 1'b0);
    count_hi(100, hi);
    do_write(192, 1'b0, 0, 1'b1, 1'b1);
    chk("R7 pending set", int'(upd_pending), 1);
    count_hi(155, hi); chk("R7 old period kept", hi, 0);
    chk("R7 pending cleared", int'(upd_pending), 0);
    count_hi(256, hi); chk("R7 new period", hi, 192);
  endtask

  task automatic t_overwrite;
    int hi;
    start(64, 1'b0, 1'b0);
    count_hi(100, hi);
    do_write(10, 1'b0, 0, 1'b1, 1'b1);
    do_write(30, 1'b0, 0, 1'b1, 1'b1);
    count_hi(154, hi); chk("R8 old kept", hi, 0);
    count_hi(256, hi); chk("R8 latest wins", hi, 30);
  endtask

  task automatic t_cancel;
    int hi;
    start(64, 1'b0, 1'b0);
    count_hi(100, hi);
    do_write(10, 1'b0, 0, 1'b1, 1'b1);
    do_write(200, 1'b0, 0, 1'b1, 1'b0);
    chk("R9 pending cleared", int'(upd_pending), 0);
    count_hi(154, hi); chk("R9 immediate live", hi, 98);
    count_hi(256, hi); chk("R9 shadow discarded", hi, 200);
  endtask

  task automatic t_polarity;
    int hi;
    start(64, 1'b0, 1'b0);
    count_hi(100, hi);
    do_write(64, 1'b0, 1'b1, 1'b1, 1'b1);
    count_hi(155, hi); chk("R10 polarity held", hi, 0);
    count_hi(256, hi); chk("R10 polarity at wrap", hi, 192);
  endtask

  task automatic t_disable;
    int hi;
    start(0, 1'b1, 1'b0);
    count_hi(50, hi);
    do_write(0, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R11 low at once", int'(pwm_out), 0);
    count_hi(20, hi); chk("R11 held low", hi, 0);
    start(0, 1'b1, 1'b1);
    chk("R11 inverted full runs low", int'(pwm_out), 0);
    do_write(0, 1'b1, 1'b1, 1'b0, 1'b0);
    count_hi(20, hi); chk("R11 inverted idle high", hi, 20);
  endtask

  task automatic t_reenable;
    int hi;
    start(200, 1'b0, 1'b0);
    count_hi(30, hi);
    do_write(200, 1'b0, 1'b0, 1'b0, 1'b0);
    count_hi(5, hi);
    do_write(10, 1'b0, 1'b0, 1'b1, 1'b0);
    count_hi(10, hi); chk("R12 restart pulse", hi, 10);
    chk("R12 pulse ends at 10", int'(pwm_out), 0);
    count_hi(246, hi); chk("R12 rest of period", hi, 0);
    chk("R12 next period", int'(pwm_out), 1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_valid = 1'b0; wr_duty = '0; wr_full = 1'b0;
    wr_inv = 1'b0; wr_run = 1'b0; wr_defer = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_basic;
    t_zero_full;
    t_invert;
    t_immediate;
    t_deferred;
    t_overwrite;
    t_cancel;
    t_polarity;
    t_disable;
    t_reenable;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule